// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Front-End

This block is the synchronous control and data path of a pipelined static memory with a small word array inside. On every rising clock edge where the clock enable is active it samples three chip selects, a read/write strobe, per-lane write enables and an address. It opens one access slot per enabled edge. A read slot loads the addressed word into an output register at the following enabled edge. A write slot takes its data at the following enabled edge, so the data arrives one clock behind its address. Reads and writes therefore share one timing shape, and no idle turnaround cycle is needed between them.

The data bus itself lives outside the block. The block returns the read word and a bus-drive enable. That enable mixes the asynchronous output-enable pin with masking that depends on the current slot. The bus is kept quiet while a write's data is on it, in the first slot after the device leaves deselect, and in any deselected slot. Holding the clock enable inactive freezes the whole pipeline, including the slot state, and does not deselect the device.

The slot sequencer has five states. SLOT_IDLE is deselected. SLOT_FIRST_RD and SLOT_FIRST_WR are the first selected read or write slot after SLOT_IDLE. SLOT_READ and SLOT_WRITE are the steady selected slots. On an enabled edge the next state is chosen as follows:
- Any state goes to SLOT_IDLE when the device is not selected.
- SLOT_IDLE goes to SLOT_FIRST_WR on a selected write and to SLOT_FIRST_RD on a selected read.
- Every other state goes to SLOT_WRITE on a selected write and to SLOT_READ on a selected read.
- A disabled edge keeps every state.

Top module: `sram_pipe_front`

## Requirements
- R1: The device is selected at an enabled edge only when cs1_n=0, cs2=1 and cs3_n=0. Any other combination produces a deselected slot, and a write strobe in that slot changes no stored data.
- R2: While cke_n=1, a clock edge changes nothing: the stored array, rdata, the slot state and dq_oe stay as they were.
- R3: For a read whose address is captured at enabled edge k, rdata holds the stored word at that address after enabled edge k+1.
- R4: dq_oe is 1 only while oe_n=0. The path from oe_n to dq_oe has no register, so dq_oe falls at once when oe_n rises.
- R5: dq_oe is 0 during a write slot, which is the cycle that carries that write's data.
- R6: dq_oe is 0 during the first selected slot after a deselected slot.
- R7: dq_oe is 0 during a deselected slot. dq_oe is 1 exactly when oe_n=0, the current slot is a steady read, and the previous enabled slot was a read.
- R8: The word is split into lanes of 9 bits. Lane i is bits [9i+8:9i], and bit 8 of each lane is its parity bit. bw_n[i]=0 writes lane i. bw_n[i]=1 leaves lane i unchanged.
- R9: Write data is sampled from wdata at the enabled edge after the one that captured the write address. wdata at the address edge is not used.
- R10: During and right after reset the device is deselected, dq_oe=0, rdata=0 and every stored word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| cke_n | input | 1 | Clock enable, active low |
| we_n | input | 1 | Write strobe, 0 = write, 1 = read |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*9 | Write data with per-lane parity |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*9 | Registered read word |
| dq_oe | output | 1 | Bus-drive enable |

## Verification
The bench attacks the masking of dq_oe. It runs reads that directly follow a deselect or a write, and writes that directly follow reads. A design that decided bus drive from oe_n alone, or from the previous slot only, would drive the bus during write data or on the first slot out of deselect. It also holds cke_n high for several edges while the address, strobe and data toggle. A pipeline that ignored the stall would update rdata or the array. Back-to-back writes carry deliberately wrong data on their address cycle, so a design that took data on the address edge would store the wrong word. Partial-lane writes and every non-selecting chip-select pattern then show up as wrong words on read-back.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [2:0] {
        SLOT_IDLE     = 3'd0,
        SLOT_FIRST_RD = 3'd1,
        SLOT_FIRST_WR = 3'd2,
        SLOT_READ     = 3'd3,
        SLOT_WRITE    = 3'd4
    } slot_e;

    function automatic logic slot_is_wr(input slot_e s);
        return (s == SLOT_FIRST_WR) || (s == SLOT_WRITE);
    endfunction

    function automatic logic slot_is_rd(input slot_e s);
        return (s == SLOT_FIRST_RD) || (s == SLOT_READ);
    endfunction

endpackage

// File: rtl/sram_slot_fsm.sv
module sram_slot_fsm
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LANES-1:0]  bw_n_in,
    output slot_e             slot,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [LANES-1:0]  slot_bw_n
);

    slot_e slot_nxt;

    // state register plus captured address/lane mask of the slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot      <= SLOT_IDLE;
            slot_addr <= '0;
            slot_bw_n <= '1;
        end else if (adv) begin
            slot      <= slot_nxt;
            slot_addr <= addr_in;
            slot_bw_n <= bw_n_in;
        end
    end

    // next-state selection
    always_comb begin
        slot_nxt = SLOT_IDLE;
        unique case (slot)
            SLOT_IDLE: begin
                if (!sel)    slot_nxt = SLOT_IDLE;
                else if (wr) slot_nxt = SLOT_FIRST_WR;
                else         slot_nxt = SLOT_FIRST_RD;
            end
            SLOT_FIRST_RD, SLOT_FIRST_WR, SLOT_READ, SLOT_WRITE: begin
                if (!sel)    slot_nxt = SLOT_IDLE;
                else if (wr) slot_nxt = SLOT_WRITE;
                else         slot_nxt = SLOT_READ;
            end
            default: slot_nxt = SLOT_IDLE;
        endcase
    end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/sram_read_stage.sv
module sram_read_stage #(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              rd_slot,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_vld
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_vld <= 1'b0;
        end else if (adv) begin
            rd_vld <= rd_slot;
            if (rd_slot) rdata <= word_in;
        end
    end

endmodule

// File: rtl/sram_pipe_front.sv
module sram_pipe_front
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs1_n,
    input  logic                     cs2,
    input  logic                     cs3_n,
    input  logic                     cke_n,
    input  logic                     we_n,
    input  logic [LANES-1:0]         bw_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic                     oe_n,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     dq_oe
);

    localparam int WORD_W = LANES * LANE_W;

    logic              adv;
    logic              sel;
    slot_e             slot;
    logic [ADDR_W-1:0] slot_addr;
    logic [LANES-1:0]  slot_bw_n;
    logic [WORD_W-1:0] word_rd;
    logic              rd_vld;
    logic              wr_slot;

    assign adv     = !cke_n;
    assign sel     = !cs1_n && cs2 && !cs3_n;
    assign wr_slot = slot_is_wr(slot);

    sram_slot_fsm #(.ADDR_W(ADDR_W), .LANES(LANES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .sel       (sel),
        .wr        (!we_n),
        .addr_in   (addr),
        .bw_n_in   (bw_n),
        .slot      (slot),
        .slot_addr (slot_addr),
        .slot_bw_n (slot_bw_n)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (adv && wr_slot && !slot_bw_n[g]),
            .addr  (slot_addr),
            .wdata (wdata[g*LANE_W +: LANE_W]),
            .rdata (word_rd[g*LANE_W +: LANE_W])
        );
    end

    sram_read_stage #(.WORD_W(WORD_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .rd_slot (slot_is_rd(slot)),
        .word_in (word_rd),
        .rdata   (rdata),
        .rd_vld  (rd_vld)
    );

    // output process: asynchronous enable gated by slot masking
    always_comb begin
        dq_oe = 1'b0;
        unique case (slot)
            SLOT_READ:                                         dq_oe = !oe_n && rd_vld;
            SLOT_IDLE, SLOT_FIRST_RD, SLOT_FIRST_WR, SLOT_WRITE: dq_oe = 1'b0;
            default:                                           dq_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/sram_pipe_front_chk.sv
module sram_pipe_front_chk #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              cke_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [WORD_W-1:0] rdata,
    input logic              dq_oe
);

    logic sel_in;
    logic last_desel;

    assign sel_in = !cs1_n && cs2 && !cs3_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      last_desel <= 1'b1;
        else if (!cke_n) last_desel <= !sel_in;
    end

    AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R4

    AST_STALL_HOLDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(rdata)); // R2

    AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && sel_in && !we_n) |=> !dq_oe); // R5

    AST_FIRST_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && sel_in && last_desel) |=> !dq_oe); // R6

    AST_DESEL_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !sel_in) |=> !dq_oe); // R7

endmodule

bind sram_pipe_front sram_pipe_front_chk #(.WORD_W(LANES*sram_pipe_pkg::LANE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs1_n (cs1_n),
    .cs2   (cs2),
    .cs3_n (cs3_n),
    .cke_n (cke_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .rdata (rdata),
    .dq_oe (dq_oe)
);

// File: tb/test_sram_pipe_front.sv
`timescale 1ns/1ps
module test_sram_pipe_front;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int WW = NL * 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
    logic          cke_n = 1'b0, we_n = 1'b1, oe_n = 1'b1;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wdata = '0;
    logic [WW-1:0] rdata;
    logic          dq_oe;

    always #2.5 clk = ~clk;

    sram_pipe_front #(.ADDR_W(AW), .LANES(NL)) i_sram_pipe_front (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .cke_n(cke_n), .we_n(we_n), .bw_n(bw_n), .addr(addr), .wdata(wdata),
        .oe_n(oe_n), .rdata(rdata), .dq_oe(dq_oe)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string tag   = "R3";

    // bench model: 0 idle, 1 first read, 2 first write, 3 read, 4 write
    int            m_st = 0;
    logic [AW-1:0] m_addr = '0;
    logic [NL-1:0] m_bw = '1;
    bit            m_rdvld = 1'b0;
    logic [WW-1:0] m_rdata = '0;
    logic [WW-1:0] mem [64];

    function automatic bit f_sel(logic a, logic b, logic c);
        return !a && b && !c;
    endfunction

    function automatic logic [WW-1:0] f_merge(logic [WW-1:0] old_w, logic [WW-1:0] new_w,
                                              logic [NL-1:0] bw);
        logic [WW-1:0] r = old_w;
        for (int i = 0; i < NL; i++)
            if (!bw[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
        return r;
    endfunction

    function automatic bit f_drive(logic oe);
        return !oe && m_rdvld && (m_st == 3);
    endfunction

    function automatic string f_drv_tag(logic oe);
        if (oe)             return "R4";
        if (m_st == 0)      return "R7";
        if (m_st == 1 || m_st == 2) return "R6";
        if (m_st == 4)      return "R5";
        return "R7";
    endfunction

    task automatic chk(string t, logic [WW-1:0] act, logic [WW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic model_edge();
        bit s;
        if (cke_n) return;
        s = f_sel(cs1_n, cs2, cs3_n);
        if (m_st == 2 || m_st == 4) mem[m_addr] = f_merge(mem[m_addr], wdata, m_bw);
        if (m_st == 1 || m_st == 3) begin
            m_rdata = mem[m_addr];
            m_rdvld = 1'b1;
        end else begin
            m_rdvld = 1'b0;
        end
        if (!s)             m_st = 0;
        else if (m_st == 0) m_st = we_n ? 1 : 2;
        else                m_st = we_n ? 3 : 4;
        m_addr = addr;
        m_bw   = bw_n;
    endtask

    // called at a falling edge: apply inputs, check, run one rising edge
    task automatic step(logic c1, logic c2, logic c3, logic ck, logic we,
                        logic [NL-1:0] bw, logic [AW-1:0] a, logic [WW-1:0] wd, logic oe);
        cs1_n = c1; cs2 = c2; cs3_n = c3; cke_n = ck; we_n = we;
        bw_n = bw; addr = a; wdata = wd; oe_n = 1'b1;
        #0.5;
        chk("R4 oe_n high", {{(WW-1){1'b0}}, dq_oe}, '0);
        oe_n = oe;
        #0.5;
        chk(f_drv_tag(oe), {{(WW-1){1'b0}}, dq_oe}, {{(WW-1){1'b0}}, f_drive(oe)});
        chk(tag, rdata, m_rdata);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [WW-1:0] wd, logic [NL-1:0] bw);
        step(0, 1, 0, 0, 0, bw, a, wd, 0);
    endtask

    task automatic rd(logic [AW-1:0] a, logic [WW-1:0] wd);
        step(0, 1, 0, 0, 1, '1, a, wd, 0);
    endtask

    function automatic logic [WW-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    initial begin
        void'($urandom(32'd7711));
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 dq_oe in reset", {{(WW-1){1'b0}}, dq_oe}, '0);
        chk("R10 rdata in reset", rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R10";
        rd(5, '0);
        rd(5, '0);
        rd(5, '0);

        // R9: back-to-back writes, address-cycle wdata is junk
        tag = "R9";
        wr(0, '1, '0);
        for (int i = 1; i < 9; i++) wr(i[AW-1:0], {4{9'(i * 37)}}, '0);
        rd(0, '1);
        for (int i = 1; i < 9; i++) rd(i[AW-1:0], '1);
        rd(0, '0);

        // R8: partial lanes
        tag = "R8";
        wr(3, '0, 4'b1010);
        rd(3, {4{9'h1A5}});
        rd(3, '0);
        rd(3, '0);
        wr(4, '0, 4'b0111);
        rd(4, {4{9'h0FF}});
        rd(4, '0);
        rd(4, '0);

        // R1: every non-selecting combination with a write strobe
        tag = "R1";
        for (int c = 0; c < 8; c++) begin
            if (c == 3'b010) continue;
            step(c[2], c[1], c[0], 0, 0, '0, 1, '0, 0);
            step(c[2], c[1], c[0], 0, 0, '0, 1, '1, 0);
        end
        rd(1, '0);
        rd(1, '0);
        rd(1, '0);

        // R2: stall mid-stream
        tag = "R2";
        rd(2, '0);
        rd(7, '0);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 1, i[0], '0, 6'(i + 20), rnd_word(), 0);
        rd(2, '0);
        rd(2, '0);

        // R6/R3: read after deselect, then read after write
        tag = "R3";
        step(1, 1, 0, 0, 1, '1, 0, '0, 0);
        rd(5, '0);
        rd(6, '0);
        rd(7, '0);
        wr(9, '0, '0);
        rd(9, {4{9'h133}});
        rd(9, '0);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic c1, c2, c3;
            bit   sel_pick = ($urandom % 10) < 8;
            c1 = sel_pick ? 1'b0 : 1'($urandom);
            c2 = sel_pick ? 1'b1 : 1'($urandom);
            c3 = sel_pick ? 1'b0 : 1'($urandom);
            tag = "R3";
            step(c1, c2, c3, ($urandom % 8) == 0, 1'($urandom), 4'($urandom),
                 6'($urandom % 8), rnd_word(), ($urandom % 4) == 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule